// File: doc/BRIEF.md
# Per-Hart Inter-Processor Interrupt Register Bank

This block gives each hart of a multi-hart cluster one 32-bit memory-mapped word. Software on any hart writes that word to send a software interrupt to the matching hart. Each hart has one interrupt output. The word for hart `i` sits at byte offset `4*i` from the bank base. A single shared address selects the word for both writes and reads.

A parameter picks one of two variants.

- **Machine variant:** bit 0 of each word is a pending level. Software can set it, clear it and read it back. The output follows the stored level.
- **Supervisor variant:** the bank only signals. Writing 1 sends a one-cycle set pulse on the hart's output, for an external pending bit to capture. Writing 0 does nothing, and every read returns zero.

Only complete 32-bit writes are honoured. Writes to unmapped or misaligned offsets are dropped, and reads from them return zero.

Top module: `ipi_bank`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `irq_o` is all zero and `bus_rdata` is zero.
- R2: In the machine variant, an accepted write with `bus_wdata[0]=1` to offset `4*i` sets `irq_o[i]` from the next cycle on. No other hart's output changes.
- R3: In the machine variant, an accepted write with `bus_wdata[0]=0` clears `irq_o[i]` in the next cycle. Bits 31..1 of the write data have no effect.
- R4: In the machine variant, a read of offset `4*i` returns the pending bit of hart `i` in `bus_rdata[0]`, with bits 31..1 zero, on the cycle after `bus_ren`. When `bus_ren` is low, `bus_rdata` is zero.
- R5: In the supervisor variant, an accepted write with `bus_wdata[0]=1` to offset `4*i` makes `irq_o[i]` high for exactly the next cycle. At all other times `irq_o` is zero.
- R6: In the supervisor variant, a write with `bus_wdata[0]=0` leaves every output low, and every read returns zero.
- R7: A write is accepted only when all four bits of `bus_wstrb` are 1. A write with any strobe bit low leaves every output and every pending bit unchanged.
- R8: An offset is mapped only when `bus_addr[1:0]=0` and `bus_addr/4 < NUM_HARTS`. Writes to other offsets change nothing, and reads from them return zero.
- R9: When a read and an accepted write hit the same word in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset within the bank, shared by read and write |
| bus_wen | input | 1 | Write request |
| bus_wstrb | input | 4 | Byte-lane strobes; all must be set for a write to count |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_ren | input | 1 | Read request |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_ren` |
| irq_o | output | NUM_HARTS | Per-hart software interrupt (level or set pulse) |

## Verification
A wrong pending bit in the machine variant shows up on `irq_o` one cycle after the write that caused it. It also shows on `bus_rdata` one cycle after any read of that word, so a random mix of writes and reads exposes it within a few accesses. In the supervisor variant, an extra or stuck pulse shows as `irq_o` high on a cycle that did not follow an accepted write of 1. A decode fault shows as the wrong hart changing, or as a change after a partial, misaligned or out-of-range write. Two instances, one per variant, receive the same traffic and are compared each cycle against a bench model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int IPI_DATA_W = 32;
  localparam int IPI_STRB_W = IPI_DATA_W / 8;

  typedef enum logic {
    IPI_MACHINE    = 1'b0,
    IPI_SUPERVISOR = 1'b1
  } ipi_variant_e;

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode #(
  parameter int NUM_HARTS = 1,
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_HARTS);

  logic [WORD_W-1:0] word;

  assign word = addr[ADDR_W-1:2];
  assign hit  = (addr[1:0] == 2'b00) && (word < LIMIT);
  assign idx  = word[IDX_W-1:0];
endmodule

// File: rtl/ipi_hart_cell.sv
module ipi_hart_cell
  import ipi_pkg::*;
#(
  parameter ipi_variant_e VARIANT = IPI_MACHINE
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic pend,
  output logic irq
);
  generate
    if (VARIANT == IPI_MACHINE) begin : g_level
      logic level_q;
      always_ff @(posedge clk) begin
        if (rst)         level_q <= 1'b0;
        else if (wr_hit) level_q <= wr_bit;
      end
      assign pend = level_q;
      assign irq  = level_q;
    end else begin : g_pulse
      logic pulse_q;
      always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= wr_hit & wr_bit;
      end
      assign pend = 1'b0;
      assign irq  = pulse_q;
    end
  endgenerate
endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
  import ipi_pkg::*;
#(
  parameter int NUM_HARTS = 1,
  parameter int IDX_W     = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ren,
  input  logic                  hit,
  input  logic [IDX_W-1:0]      idx,
  input  logic [NUM_HARTS-1:0]  pend_vec,
  output logic [IPI_DATA_W-1:0] rdata
);
  logic sel_bit;

  always_comb begin
    sel_bit = 1'b0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (idx == IDX_W'(h)) sel_bit = pend_vec[h];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              rdata <= '0;
    else if (ren && hit)  rdata <= {{(IPI_DATA_W-1){1'b0}}, sel_bit};
    else                  rdata <= '0;
  end
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank
  import ipi_pkg::*;
#(
  parameter int           NUM_HARTS = 1,
  parameter int           ADDR_W    = 8,
  parameter ipi_variant_e VARIANT   = IPI_MACHINE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wen,
  input  logic [IPI_STRB_W-1:0] bus_wstrb,
  input  logic [IPI_DATA_W-1:0] bus_wdata,
  input  logic                  bus_ren,
  output logic [IPI_DATA_W-1:0] bus_rdata,
  output logic [NUM_HARTS-1:0]  irq_o
);
  localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic                 hit;
  logic [IDX_W-1:0]     idx;
  logic                 wr_ok;
  logic [NUM_HARTS-1:0] pend_vec;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[IPI_DATA_W-1:1];

  ipi_decode #(
    .NUM_HARTS(NUM_HARTS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr(bus_addr),
    .hit (hit),
    .idx (idx)
  );

  assign wr_ok = bus_wen && (&bus_wstrb) && hit;

  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic sel;
      assign sel = wr_ok && (idx == IDX_W'(h));
      ipi_hart_cell #(
        .VARIANT(VARIANT)
      ) u_cell (
        .clk   (clk),
        .rst   (rst),
        .wr_hit(sel),
        .wr_bit(bus_wdata[0]),
        .pend  (pend_vec[h]),
        .irq   (irq_o[h])
      );
    end
  endgenerate

  ipi_read_port #(
    .NUM_HARTS(NUM_HARTS),
    .IDX_W    (IDX_W)
  ) u_rport (
    .clk     (clk),
    .rst     (rst),
    .ren     (bus_ren),
    .hit     (hit),
    .idx     (idx),
    .pend_vec(pend_vec),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/ipi_bank_chk.sv
module ipi_bank_chk
  import ipi_pkg::*;
#(
  parameter int           NUM_HARTS = 1,
  parameter int           ADDR_W    = 8,
  parameter ipi_variant_e VARIANT   = IPI_MACHINE
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_wen,
  input logic [IPI_STRB_W-1:0] bus_wstrb,
  input logic [IPI_DATA_W-1:0] bus_wdata,
  input logic                  bus_ren,
  input logic [IPI_DATA_W-1:0] bus_rdata,
  input logic [NUM_HARTS-1:0]  irq_o
);
  localparam int CIDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic mapped;
  logic take;
  logic [CIDX_W-1:0] cidx;

  assign mapped = (bus_addr[1:0] == 2'b00) && (int'(bus_addr >> 2) < NUM_HARTS);
  assign take   = bus_wen && (bus_wstrb == 4'hF) && mapped;
  assign cidx   = CIDX_W'(bus_addr >> 2);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $fell(rst) |-> (irq_o == '0 && bus_rdata == '0));

  assert_rdata_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[IPI_DATA_W-1:1] == '0);

  assert_idle_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !bus_ren |=> bus_rdata == '0);

  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && !mapped) |=> bus_rdata == '0);

  generate
    if (VARIANT == IPI_MACHINE) begin : g_mach
      assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> irq_o[$past(cidx)] == $past(bus_wdata[0]));
      assert_partial_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_wstrb != 4'hF) |=> $stable(irq_o));
      assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && !mapped) |=> $stable(irq_o));
    end else begin : g_sup
      assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_o));
      assert_pulse_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
        !(take && bus_wdata[0]) |=> irq_o == '0);
      assert_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rdata == '0);
      assert_partial_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_wstrb != 4'hF) |=> irq_o == '0);
    end
  endgenerate
endmodule

bind ipi_bank ipi_bank_chk #(
  .NUM_HARTS(NUM_HARTS),
  .ADDR_W   (ADDR_W),
  .VARIANT  (VARIANT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wen  (bus_wen),
  .bus_wstrb(bus_wstrb),
  .bus_wdata(bus_wdata),
  .bus_ren  (bus_ren),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o)
);

// File: tb/ipi_bank_bench.sv
module ipi_bank_bench;
  localparam int NH = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wen = 1'b0;
  logic [3:0]    bus_wstrb = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_ren = 1'b0;
  logic [31:0]   m_rdata, s_rdata;
  logic [NH-1:0] m_irq, s_irq;

  int checks = 0;
  int errors = 0;
  logic [NH-1:0] model_pend = '0;

  always #2 clk = ~clk;

  ipi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .VARIANT(ipi_pkg::IPI_MACHINE)) u_ipi_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_ren(bus_ren),
    .bus_rdata(m_rdata), .irq_o(m_irq));

  ipi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .VARIANT(ipi_pkg::IPI_SUPERVISOR)) u_ipi_bank_s (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_ren(bus_ren),
    .bus_rdata(s_rdata), .irq_o(s_irq));

  function automatic bit is_mapped(logic [AW-1:0] a);
    return (a[1:0] == 2'b00) && (int'(a >> 2) < NH);
  endfunction

  function automatic bit is_taken(logic [AW-1:0] a, logic w, logic [3:0] s);
    return w && (s == 4'hF) && is_mapped(a);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(string tag, logic [AW-1:0] a, logic w, logic [3:0] s,
                        logic [31:0] d, logic r);
    logic [31:0]   exp_m_rd;
    logic [NH-1:0] exp_s_irq;
    @(negedge clk);
    bus_addr = a; bus_wen = w; bus_wstrb = s; bus_wdata = d; bus_ren = r;
    exp_m_rd  = (r && is_mapped(a)) ? {31'b0, model_pend[a >> 2]} : 32'h0;
    exp_s_irq = '0;
    if (is_taken(a, w, s)) begin
      model_pend[a >> 2] = d[0];
      if (d[0]) exp_s_irq[a >> 2] = 1'b1;
    end
    @(posedge clk);
    #1;
    check(tag, "machine irq", 32'(m_irq), 32'(model_pend));
    check(tag, "machine rdata", m_rdata, exp_m_rd);
    check(tag, "supervisor irq", 32'(s_irq), 32'(exp_s_irq));
    check(tag, "supervisor rdata", s_rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "machine irq in reset", 32'(m_irq), 32'h0);
    check("R1", "supervisor irq in reset", 32'(s_irq), 32'h0);
    check("R1", "machine rdata in reset", m_rdata, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    access("R1", 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);

    access("R2", 8'h08, 1'b1, 4'hF, 32'h1, 1'b0);
    access("R5", 8'h00, 1'b0, 4'h0, 32'h0, 1'b0);
    access("R4", 8'h08, 1'b0, 4'h0, 32'h0, 1'b1);
    access("R4", 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);
    access("R3", 8'h08, 1'b1, 4'hF, 32'hFFFF_FFFE, 1'b0);
    access("R6", 8'h04, 1'b1, 4'hF, 32'h0, 1'b1);
    access("R7", 8'h0C, 1'b1, 4'h7, 32'h1, 1'b0);
    access("R7", 8'h0C, 1'b1, 4'hE, 32'h1, 1'b1);
    access("R2", 8'h00, 1'b1, 4'hF, 32'h1, 1'b0);
    access("R8", 8'h10, 1'b1, 4'hF, 32'h1, 1'b1);
    access("R8", 8'h0D, 1'b1, 4'hF, 32'h0, 1'b0);
    access("R8", 8'h01, 1'b0, 4'h0, 32'h0, 1'b1);
    access("R9", 8'h00, 1'b1, 4'hF, 32'h0, 1'b1);
    access("R9", 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);
    access("R5", 8'h0C, 1'b1, 4'hF, 32'h3, 1'b0);
    access("R5", 8'h0C, 1'b1, 4'hF, 32'h3, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [3:0]    s;
      a = AW'($urandom_range(0, 23));
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      s = ($urandom_range(0, 1) == 1) ? 4'hF : 4'($urandom);
      access("R2/R3/R4/R5/R7/R8 random", a, 1'($urandom_range(0, 9) < 7), s,
             $urandom, 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule